// File: doc/BRIEF.md
# ADC Result Register Bank with Byte-Latch

This block keeps the most recent analog-to-digital conversion result for each channel slot. A conversion engine writes a 10-bit sample and a slot index on a single-cycle strobe. The bank stores the sample left-justified in a 16-bit word, with the unused low bits held at zero. A host on an 8-bit data bus reads the bank one byte at a time.

Byte reads can tear a word when a new sample lands between the two halves. To prevent this, a read of a slot's upper byte also copies that slot's lower byte into one shared holding latch. The following lower-byte read returns the latch and not the live register, so the host gets a coherent word when it reads upper byte first and lower byte second. Read data appears one clock after the read strobe.

Top module: `adc_result_bank`

## Requirements
- R1: A synchronous active-high reset clears every result word, the holding latch and the read data output to zero.
- R2: A write strobe stores the 10-bit sample in bits 15..6 of the indexed word on the next clock edge. Bits 5..0 of the word become zero, and the other words are unchanged.
- R3: A read with byte select addr[0]=0 returns bits 15..8 of the word indexed by addr[2:1] on rdata, one cycle after rd_en.
- R4: An upper-byte read loads bits 7..0 of the same word into the holding latch. That value is {sample[1:0], 6'b0}.
- R5: A read with addr[0]=1 returns the holding latch, one cycle after rd_en. A write to the word after its upper byte was read does not change this value.
- R6: There is one holding latch for all words. Any later upper-byte read overwrites it, whichever word that read targets.
- R7: A read in the same cycle as a write to the same word returns the value the word held before the write.
- R8: The six lowest bits of any lower byte returned on rdata are zero.
- R9: While rd_en is low, rdata keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Conversion result strobe |
| wr_idx | input | 2 | Result word index for the strobe |
| wr_sample | input | 10 | Conversion sample |
| rd_en | input | 1 | Host byte read strobe |
| addr | input | 3 | [2:1] word index, [0] byte select (0 = upper) |
| rdata | output | 8 | Read byte, valid the cycle after rd_en |

## Verification
The hardest case to reach is a lower-byte read that gets a value the live register no longer holds. The bench reaches it by reading an upper byte and then writing a new sample to the same word before the lower-byte read. It also sets up two upper-byte reads to different words before one lower-byte read. A read and a write to the same word are also placed in the same cycle, so the old value must be seen on rdata and in the latch.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;
  parameter int SAMPLE_W = 10;
  parameter int WORD_W   = 16;
  parameter int BYTE_W   = 8;
  parameter int PAD_W    = WORD_W - SAMPLE_W;

  // Place a sample at the top of a result word, zero below it.
  function automatic logic [WORD_W-1:0] justify(input logic [SAMPLE_W-1:0] s);
    return {s, {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/adc_rb_store.sv
module adc_rb_store
  import adc_rb_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_idx,
  input  logic [SAMPLE_W-1:0]                wr_sample,
  output logic [NUM_REGS-1:0][WORD_W-1:0]    words_o
);
  logic [WORD_W-1:0] wr_word;
  assign wr_word = justify(wr_sample);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst)      words_o[g] <= '0;
      else if (hit) words_o[g] <= wr_word;
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> words_o[$past(wr_idx)] == {$past(wr_sample), {PAD_W{1'b0}}}); // R2
endmodule

// File: rtl/adc_rb_rdport.sv
module adc_rb_rdport
  import adc_rb_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter int ADDR_W   = IDX_W + 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_REGS-1:0][WORD_W-1:0]  words_i,
  input  logic                             rd_en,
  input  logic [ADDR_W-1:0]                addr,
  output logic [BYTE_W-1:0]                rdata
);
  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] sel_word;
  logic              hi_rd;
  logic              lo_rd;
  logic [BYTE_W-1:0] hold_q;

  assign rd_idx   = addr[ADDR_W-1:1];
  assign sel_word = words_i[rd_idx];
  assign hi_rd    = rd_en && !addr[0];
  assign lo_rd    = rd_en &&  addr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      hold_q <= '0;
    end else if (hi_rd) begin
      rdata  <= sel_word[WORD_W-1:BYTE_W];
      hold_q <= sel_word[BYTE_W-1:0];
    end else if (lo_rd) begin
      rdata  <= hold_q;
    end
  end

  AST_LO_FROM_HOLD: assert property (@(posedge clk) disable iff (rst)
    lo_rd |=> rdata == $past(hold_q)); // R5
  AST_HOLD_RELOAD: assert property (@(posedge clk) disable iff (rst)
    hi_rd |=> hold_q == $past(sel_word[BYTE_W-1:0])); // R6
  AST_LO_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    lo_rd |=> rdata[PAD_W-1:0] == '0); // R8
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R9
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_rb_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter int ADDR_W   = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [SAMPLE_W-1:0] wr_sample,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  output logic [BYTE_W-1:0]   rdata
);
  logic [NUM_REGS-1:0][WORD_W-1:0] words;

  adc_rb_store #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_sample(wr_sample), .words_o(words)
  );

  adc_rb_rdport #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .words_i(words), .rd_en(rd_en),
    .addr(addr), .rdata(rdata)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> rdata == '0); // R1
endmodule

// File: tb/tb_adc_result_bank.sv
module tb_adc_result_bank;
  logic       clk = 0;
  logic       rst;
  logic       wr_en;
  logic [1:0] wr_idx;
  logic [9:0] wr_sample;
  logic       rd_en;
  logic [2:0] addr;
  logic [7:0] rdata;

  int checks = 0;
  int fails  = 0;
  logic [15:0] mw [4];   // model words
  logic [7:0]  mhold;

  always #5 clk = ~clk;

  adc_result_bank dut (.*);

  function automatic logic [15:0] mword(input logic [9:0] s);
    return 16'(s) * 16'd64;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input int idx, input logic [9:0] s);
    @(negedge clk);
    wr_en = 1; wr_idx = 2'(idx); wr_sample = s;
    @(negedge clk);
    wr_en = 0;
    mw[idx] = mword(s);
  endtask

  task automatic do_read(input int idx, input bit lo, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1; addr = {2'(idx), lo};
    @(negedge clk);
    rd_en = 0;
    v = rdata;
  endtask

  task automatic model_read(input int idx, input bit lo, output logic [7:0] e);
    if (!lo) begin e = mw[idx][15:8]; mhold = mw[idx][7:0]; end
    else e = mhold;
  endtask

  task automatic rd_check(input string req, input int idx, input bit lo);
    logic [7:0] v, e;
    model_read(idx, lo, e);
    do_read(idx, lo, v);
    check(req, v, e);
  endtask

  task automatic t_reset;
    rst = 1; wr_en = 0; rd_en = 0; addr = 0; wr_idx = 0; wr_sample = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int i = 0; i < 4; i++) mw[i] = 0;
    mhold = 0;
    check("R1 rdata after reset", rdata, 8'h00);
    rd_check("R1 lo latch after reset", 0, 1);
    for (int i = 0; i < 4; i++) rd_check("R1 hi after reset", i, 0);
  endtask

  task automatic t_words;
    logic [9:0] pat [4] = '{10'h3FF, 10'h155, 10'h2AA, 10'h001};
    for (int i = 0; i < 4; i++) do_write(i, pat[i]);
    for (int i = 0; i < 4; i++) begin
      rd_check("R2 R3 hi byte", i, 0);
      rd_check("R4 R8 lo byte", i, 1);
    end
  endtask

  task automatic t_coherent;
    rd_check("R3 hi before update", 0, 0);
    do_write(0, 10'h0C2);
    rd_check("R5 lo from latch, not live", 0, 1);
    rd_check("R5 fresh hi", 0, 0);
    rd_check("R5 fresh lo", 0, 1);
  endtask

  task automatic t_shared;
    rd_check("R6 hi slot1", 1, 0);
    rd_check("R6 hi slot2", 2, 0);
    rd_check("R6 lo shows slot2", 1, 1);
  endtask

  task automatic t_collide;
    logic [7:0] v, e;
    model_read(3, 0, e);
    @(negedge clk);
    wr_en = 1; wr_idx = 2'd3; wr_sample = 10'h37E;
    rd_en = 1; addr = {2'd3, 1'b0};
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    v = rdata;
    mw[3] = mword(10'h37E);
    check("R7 same-cycle hi sees old", v, e);
    rd_check("R7 same-cycle lo sees old", 3, 1);
    rd_check("R7 next hi sees new", 3, 0);
    rd_check("R7 next lo sees new", 3, 1);
  endtask

  task automatic t_idle;
    logic [7:0] e;
    rd_check("R9 setup", 2, 0);
    e = mw[2][15:8];
    do_write(2, 10'h011);
    repeat (3) @(negedge clk);
    check("R9 rdata holds while idle", rdata, e);
  endtask

  initial begin
    t_reset();
    t_words();
    t_coherent();
    t_shared();
    t_collide();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule